// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked request stream and an external asynchronous static RAM that has a 16-bit data bus and separate enables for the upper and lower byte. Each accepted request is one read or one write of a single word. The controller converts it into a timed sequence of active-low pins: chip select, output enable, write strobe and one enable per byte lane. It also provides a split tristate bus made of an output word, a drive enable and an input word. Every timing window is a number of clock cycles. The block works it out at elaboration time by rounding the memory's nanosecond limits up against the clock period `CLK_NS`.

The request side uses a valid/ready handshake. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. The requester must hold `req_valid` and its payload steady until that edge. While an access is in progress, `req_ready` stays low, and that is the only back-pressure. Read data comes back as a single-cycle `rsp_valid` pulse. The response side has no ready signal, so the requester must always be able to take it.

Each access passes through address setup, a strobe window and a hold window. A write is ended by the write strobe rising while chip select and the byte enables are still low. That makes the write-strobe edge the one that closes the write, and data stays driven through the hold window after it. A write that arrives directly after a read gets one extra idle turnaround cycle. This keeps the memory's output drivers and the controller's drivers from overlapping.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held and directly after it, `req_ready` is 1, `rsp_valid` is 0, `mem_dq_drive` is 0, and `mem_ce_n`, `mem_oe_n`, `mem_we_n` and both bits of `mem_be_n` are 1.
- R2: A request is taken on a rising edge with `req_valid` and `req_ready` both high. `req_ready` is low from the next cycle until the access has finished. Address, lane enables, data and direction are latched at acceptance, so later changes on the request pins have no effect on that access.
- R3: In a write, `mem_we_n` is low for exactly ceil(max(8, 7, 5)/CLK_NS) cycles, at least 1. It goes low only while `mem_ce_n` is low. It rises while `mem_ce_n` and the selected byte enables are still low, so the write strobe is the edge that ends the write.
- R4: Write data is driven (`mem_dq_drive`=1) and held constant from the first cycle of chip select to its last. The controller never drives the bus while `mem_oe_n` is low.
- R5: In a read, `mem_oe_n` is low for exactly ceil(10/CLK_NS) cycles (at least 1), and `mem_we_n` stays high. Chip select stays low for one setup cycle, then the strobe window, then ceil(5/CLK_NS) hold cycles (at least 1).
- R6: `rsp_valid` is a one-cycle pulse in the cycle after the last output-enable cycle. `rsp_rdata` carries the bus word sampled on that edge, and any lane whose request enable was 0 is forced to zero. Request enable bit 1 selects bits [15:8] and pin `mem_be_n[1]`; bit 0 selects bits [7:0] and `mem_be_n[0]`.
- R7: The byte lanes are independent. A write with only one enable bit set pulls only that `mem_be_n` bit low, so the memory keeps the other byte of the word.
- R8: When a write is accepted directly after a read, chip select stays high for two cycles between the two accesses instead of one. In all other back-to-back cases the gap is one cycle.
- R9: `mem_addr` does not change while `mem_ce_n` stays low.
- R10: With `CLK_NS`=4 a write keeps chip select low for 4 cycles: one setup cycle, two strobe cycles and one hold cycle. This meets both the 10 ns cycle minimum and the 0 ns data-hold minimum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle; request taken when both high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_be | input | DW/8 | Lane enables, bit 1 upper byte, bit 0 lower byte |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | DW | Read data, disabled lanes zero |
| mem_addr | output | AW | Address to memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_be_n | output | DW/8 | Byte-lane enables, active low |
| mem_dq_out | output | DW | Data to be driven on the bus |
| mem_dq_drive | output | 1 | Tristate drive enable for `mem_dq_out` |
| mem_dq_in | input | DW | Data read back from the bus |

## Verification
Two events can fall on the same edge: a read finishing and the controller going back to idle, and a waiting write being accepted in that same idle cycle. The turnaround decision is made on exactly that edge. The bench leaves each following request waiting on `req_valid` while the earlier access is still running, so every access is accepted in the first idle cycle. At each chip-select fall it measures the number of chip-select-high cycles and checks for two after a read-then-write and one for every other pairing. A behavioural memory in the bench commits a write only on a rising write strobe that overlaps chip select, and responses are compared against a shadow copy that is updated lane by lane.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_TURN   = 3'd1,
    ST_SETUP  = 3'd2,
    ST_STROBE = 3'd3,
    ST_HOLD   = 3'd4
  } asram_state_e;

  // nanoseconds to whole clock cycles, rounded up
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // hold window padded so the whole access meets a cycle-time floor
  function automatic int unsigned pad_hold(input int unsigned setup, input int unsigned strobe,
                                           input int unsigned hold, input int unsigned floor_cyc);
    return (setup + strobe + hold >= floor_cyc) ? hold : (floor_cyc - setup - strobe);
  endfunction

endpackage

// File: rtl/asram_timer.sv
`timescale 1ns/1ps
module asram_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/asram_fsm.sv
`timescale 1ns/1ps
module asram_fsm
  import asram_pkg::*;
#(
  parameter int unsigned CW        = 4,
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned WSTB_CYC  = 1,
  parameter int unsigned WHOLD_CYC = 1,
  parameter int unsigned RSTB_CYC  = 1,
  parameter int unsigned RHOLD_CYC = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic         req_we,
  input  logic         tmr_done,
  output logic         req_ready,
  output logic         acc,
  output logic         cap_en,
  output logic         tmr_load,
  output logic [CW-1:0] tmr_val,
  output asram_state_e state_d,
  output logic         op_we_d
);

  localparam logic [CW-1:0] L_SETUP = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] L_WSTB  = CW'(WSTB_CYC - 1);
  localparam logic [CW-1:0] L_WHOLD = CW'(WHOLD_CYC - 1);
  localparam logic [CW-1:0] L_RSTB  = CW'(RSTB_CYC - 1);
  localparam logic [CW-1:0] L_RHOLD = CW'(RHOLD_CYC - 1);

  asram_state_e state_q;
  logic         op_we_q;
  logic         last_rd_q;

  always_comb begin
    state_d  = state_q;
    op_we_d  = op_we_q;
    acc      = 1'b0;
    cap_en   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          acc      = 1'b1;
          op_we_d  = req_we;
          tmr_load = 1'b1;
          if (req_we && last_rd_q) begin
            state_d = ST_TURN;
            tmr_val = '0;
          end else begin
            state_d = ST_SETUP;
            tmr_val = L_SETUP;
          end
        end
      end
      ST_TURN: begin
        if (tmr_done) begin
          state_d  = ST_SETUP;
          tmr_load = 1'b1;
          tmr_val  = L_SETUP;
        end
      end
      ST_SETUP: begin
        if (tmr_done) begin
          state_d  = ST_STROBE;
          tmr_load = 1'b1;
          tmr_val  = op_we_q ? L_WSTB : L_RSTB;
        end
      end
      ST_STROBE: begin
        if (tmr_done) begin
          state_d  = ST_HOLD;
          cap_en   = !op_we_q;
          tmr_load = 1'b1;
          tmr_val  = op_we_q ? L_WHOLD : L_RHOLD;
        end
      end
      ST_HOLD: begin
        if (tmr_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      op_we_q   <= 1'b0;
      last_rd_q <= 1'b0;
    end else begin
      state_q <= state_d;
      op_we_q <= op_we_d;
      if (acc) last_rd_q <= !req_we;
    end
  end

  assign req_ready = (state_q == ST_IDLE);

  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R8
  turn_to_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TURN) |=> (state_q == ST_SETUP));

endmodule

// File: rtl/asram_datapath.sv
`timescale 1ns/1ps
module asram_datapath
  import asram_pkg::*;
#(
  parameter int unsigned AW = 18,
  parameter int unsigned DW = 16,
  parameter int unsigned NL = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic          cap_en,
  input  asram_state_e  state_d,
  input  logic          op_we_d,
  input  logic [AW-1:0] req_addr,
  input  logic [NL-1:0] req_be,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] mem_dq_in,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [NL-1:0] mem_be_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_drive,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);

  logic [AW-1:0] addr_q;
  logic [NL-1:0] be_q;
  logic [DW-1:0] wdata_q;
  logic [NL-1:0] be_d;
  logic          active_d;
  logic [DW-1:0] cap_word;

  logic          ce_n_q, oe_n_q, we_n_q, drive_q, rsp_q;
  logic [NL-1:0] be_n_q;
  logic [DW-1:0] rdata_q;

  assign be_d     = acc ? req_be : be_q;
  assign active_d = (state_d == ST_SETUP) || (state_d == ST_STROBE) || (state_d == ST_HOLD);

  for (genvar l = 0; l < NL; l++) begin : g_lane
    assign cap_word[l*8 +: 8] = be_q[l] ? mem_dq_in[l*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
    end else if (acc) begin
      addr_q  <= req_addr;
      be_q    <= req_be;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      be_n_q  <= '1;
      drive_q <= 1'b0;
      rsp_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ce_n_q  <= !active_d;
      oe_n_q  <= !((state_d == ST_STROBE) && !op_we_d);
      we_n_q  <= !((state_d == ST_STROBE) && op_we_d);
      be_n_q  <= active_d ? ~be_d : '1;
      drive_q <= active_d && op_we_d;
      rsp_q   <= cap_en;
      if (cap_en) rdata_q <= cap_word;
    end
  end

  assign mem_addr     = addr_q;
  assign mem_dq_out   = wdata_q;
  assign mem_ce_n     = ce_n_q;
  assign mem_oe_n     = oe_n_q;
  assign mem_we_n     = we_n_q;
  assign mem_be_n     = be_n_q;
  assign mem_dq_drive = drive_q;
  assign rsp_valid    = rsp_q;
  assign rsp_rdata    = rdata_q;

  // R4
  no_bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_drive && !mem_oe_n));

  // R3
  we_inside_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);

  // R3
  we_ends_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_ce_n);

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

  // R4
  wdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_drive && $past(mem_dq_drive)) |-> $stable(mem_dq_out));

  // R6
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned AW        = 18,
  parameter int unsigned DW        = 16,
  parameter int unsigned CLK_NS    = 10,
  parameter int unsigned T_SA_NS   = 0,
  parameter int unsigned T_PWE_NS  = 7,
  parameter int unsigned T_SCE_NS  = 8,
  parameter int unsigned T_AW_NS   = 8,
  parameter int unsigned T_BW_NS   = 7,
  parameter int unsigned T_SD_NS   = 5,
  parameter int unsigned T_HD_NS   = 0,
  parameter int unsigned T_WC_NS   = 10,
  parameter int unsigned T_AA_NS   = 10,
  parameter int unsigned T_DOE_NS  = 5,
  parameter int unsigned T_HZOE_NS = 5,
  parameter int unsigned T_RC_NS   = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_we,
  input  logic [AW-1:0]       req_addr,
  input  logic [DW/8-1:0]     req_be,
  input  logic [DW-1:0]       req_wdata,
  output logic                rsp_valid,
  output logic [DW-1:0]       rsp_rdata,
  output logic [AW-1:0]       mem_addr,
  output logic                mem_ce_n,
  output logic                mem_oe_n,
  output logic                mem_we_n,
  output logic [DW/8-1:0]     mem_be_n,
  output logic [DW-1:0]       mem_dq_out,
  output logic                mem_dq_drive,
  input  logic [DW-1:0]       mem_dq_in
);

  localparam int unsigned NL = DW / 8;

  localparam int unsigned SETUP_CYC = umax(1, ns_to_cyc(T_SA_NS, CLK_NS));
  localparam int unsigned W_ACT_NS  = umax(umax(T_PWE_NS, T_BW_NS), umax(umax(T_SCE_NS, T_AW_NS), T_SD_NS));
  localparam int unsigned WSTB_CYC  = umax(1, ns_to_cyc(W_ACT_NS, CLK_NS));
  localparam int unsigned WHOLD_CYC = pad_hold(SETUP_CYC, WSTB_CYC,
                                               umax(1, ns_to_cyc(T_HD_NS, CLK_NS)),
                                               ns_to_cyc(T_WC_NS, CLK_NS));
  localparam int unsigned RSTB_CYC  = umax(1, ns_to_cyc(umax(T_AA_NS, T_DOE_NS), CLK_NS));
  localparam int unsigned RHOLD_CYC = pad_hold(SETUP_CYC, RSTB_CYC,
                                               umax(1, ns_to_cyc(T_HZOE_NS, CLK_NS)),
                                               ns_to_cyc(T_RC_NS, CLK_NS));
  localparam int unsigned MAX_CYC   = umax(umax(SETUP_CYC, WSTB_CYC),
                                           umax(umax(WHOLD_CYC, RSTB_CYC), RHOLD_CYC));
  localparam int unsigned CW        = $clog2(MAX_CYC + 1);

  logic          acc, cap_en, tmr_load, tmr_done, op_we_d;
  logic [CW-1:0] tmr_val;
  asram_state_e  state_d;

  asram_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  asram_fsm #(
    .CW        (CW),
    .SETUP_CYC (SETUP_CYC),
    .WSTB_CYC  (WSTB_CYC),
    .WHOLD_CYC (WHOLD_CYC),
    .RSTB_CYC  (RSTB_CYC),
    .RHOLD_CYC (RHOLD_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_we    (req_we),
    .tmr_done  (tmr_done),
    .req_ready (req_ready),
    .acc       (acc),
    .cap_en    (cap_en),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .state_d   (state_d),
    .op_we_d   (op_we_d)
  );

  asram_datapath #(.AW(AW), .DW(DW), .NL(NL)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc          (acc),
    .cap_en       (cap_en),
    .state_d      (state_d),
    .op_we_d      (op_we_d),
    .req_addr     (req_addr),
    .req_be       (req_be),
    .req_wdata    (req_wdata),
    .mem_dq_in    (mem_dq_in),
    .mem_addr     (mem_addr),
    .mem_ce_n     (mem_ce_n),
    .mem_oe_n     (mem_oe_n),
    .mem_we_n     (mem_we_n),
    .mem_be_n     (mem_be_n),
    .mem_dq_out   (mem_dq_out),
    .mem_dq_drive (mem_dq_drive),
    .rsp_valid    (rsp_valid),
    .rsp_rdata    (rsp_rdata)
  );

endmodule

// File: tb/asram_ctrl_test.sv
`timescale 1ns/1ps
module asram_ctrl_test;

  localparam int CLK_PERIOD = 4;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int W_WE  = 2;  // ceil(8/4)
  localparam int W_CE  = 4;  // 1 + 2 + 1
  localparam int R_OE  = 3;  // ceil(10/4)
  localparam int R_CE  = 6;  // 1 + 3 + 2

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_be = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_drive;
  logic [1:0]    mem_be_n;
  logic [DW-1:0] mem_dq_out, mem_dq_in;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [DW-1:0] marr   [0:255];
  logic [DW-1:0] shadow [0:255];
  logic [DW-1:0] exp_q  [$];

  asram_ctrl #(.AW(AW), .DW(DW), .CLK_NS(CLK_PERIOD)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out),
    .mem_dq_drive(mem_dq_drive), .mem_dq_in(mem_dq_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: disabled lanes read back a filler byte the controller must mask
  assign mem_dq_in = (!mem_ce_n && !mem_oe_n) ?
      { mem_be_n[1] ? 8'hA5 : marr[mem_addr][15:8],
        mem_be_n[0] ? 8'hA5 : marr[mem_addr][7:0] } : 16'hFFFF;

  logic          p_we = 1, p_ce = 1, p_oe = 1, p_rsp = 0;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_dat;
  logic [1:0]    p_be = 2'b11;
  logic          p_drive = 0;
  int we_run = 0, oe_run = 0, ce_run = 0, gap = 0, last_gap = 0;
  bit win_we = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      // write commits on a rising strobe that overlapped chip select
      if (!p_we && mem_we_n && !p_ce) begin
        check(p_drive, "R4", p_drive, 1);
        if (!p_be[1]) marr[p_addr][15:8] = p_dat[15:8];
        if (!p_be[0]) marr[p_addr][7:0]  = p_dat[7:0];
        check(we_run == W_WE, "R3", we_run, W_WE);
        check(!mem_ce_n, "R3", mem_ce_n, 0);
        we_run = 0;
      end
      if (!mem_we_n) we_run++;
      if (!p_oe && mem_oe_n) begin
        check(oe_run == R_OE, "R5", oe_run, R_OE);
        oe_run = 0;
      end
      if (!mem_oe_n) begin
        oe_run++;
        check(!mem_we_n == 0, "R5", mem_we_n, 1);
      end
      if (p_ce && !mem_ce_n) begin last_gap = gap; gap = 0; end
      if (!p_ce && mem_ce_n) begin
        if (win_we) check(ce_run == W_CE, "R10", ce_run, W_CE);
        else        check(ce_run == R_CE, "R5", ce_run, R_CE);
        ce_run = 0; win_we = 0;
      end
      if (!mem_ce_n) begin ce_run++; if (!mem_we_n) win_we = 1; end
      else gap++;
      if (rsp_valid) begin
        if (exp_q.size() == 0) check(0, "R6", rsp_rdata, 0);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          check(rsp_rdata == e, "R6", rsp_rdata, e);
        end
        check(!p_rsp, "R6", p_rsp, 0);
      end
    end
    p_we = mem_we_n; p_ce = mem_ce_n; p_oe = mem_oe_n; p_rsp = rsp_valid;
    p_addr = mem_addr; p_dat = mem_dq_out; p_be = mem_be_n; p_drive = mem_dq_drive;
  end

  bit last_rd = 0;
  bit have_prev = 0;

  // called at a negedge; returns at the negedge where ready is high again
  task automatic op(input bit we, input logic [AW-1:0] a, input logic [1:0] be, input logic [DW-1:0] d);
    int n;
    int exp_busy;
    bit turn;
    turn = we && last_rd;
    req_valid = 1; req_we = we; req_addr = a; req_be = be; req_wdata = d;
    if (we) begin
      if (be[1]) shadow[a][15:8] = d[15:8];
      if (be[0]) shadow[a][7:0]  = d[7:0];
    end else begin
      exp_q.push_back({be[1] ? shadow[a][15:8] : 8'h00, be[0] ? shadow[a][7:0] : 8'h00});
    end
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    // R2: scramble request pins after acceptance
    req_valid = 0; req_we = ~we; req_addr = ~a; req_be = ~be; req_wdata = ~d;
    n = 0;
    while (!req_ready) begin n++; @(negedge clk); end
    exp_busy = (we ? W_CE : R_CE) + (turn ? 1 : 0);
    check(n == exp_busy, "R2", n, exp_busy);
    if (have_prev) check(last_gap == (turn ? 2 : 1), "R8", last_gap, turn ? 2 : 1);
    have_prev = 1;
    last_rd = !we;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      marr[i] = 16'(i * 16'h0101) ^ 16'h5A3C;
      shadow[i] = marr[i];
    end
    repeat (3) @(negedge clk);
    // R1
    check(req_ready == 1, "R1", req_ready, 1);
    check(mem_ce_n && mem_oe_n && mem_we_n, "R1", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
    check(mem_be_n == 2'b11, "R1", mem_be_n, 2'b11);
    check(!mem_dq_drive && !rsp_valid, "R1", {mem_dq_drive, rsp_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    check(req_ready && mem_ce_n && !rsp_valid, "R1", {req_ready, mem_ce_n, rsp_valid}, 3'b110);

    op(1, 8'h10, 2'b11, 16'hBEEF);
    op(1, 8'h11, 2'b11, 16'h1234);
    op(0, 8'h10, 2'b11, 16'h0);
    op(0, 8'h11, 2'b10, 16'h0);      // R6 lower lane masked
    op(0, 8'h11, 2'b01, 16'h0);      // R6 upper lane masked
    op(1, 8'h10, 2'b01, 16'h77AA);   // R7 lower only (read->write turnaround R8)
    op(1, 8'h10, 2'b10, 16'h5533);   // R7 upper only
    op(0, 8'h10, 2'b11, 16'h0);      // expect 55AA
    op(0, 8'h20, 2'b11, 16'h0);      // read->read
    op(1, 8'h20, 2'b00, 16'hFFFF);   // no lanes: word untouched
    op(0, 8'h20, 2'b11, 16'h0);
    for (int i = 0; i < 24; i++) begin
      op(1, 8'(8'h40 + i), 2'(i % 4), 16'(i * 16'h1357 + 16'h0F0F));
      op(0, 8'(8'h40 + i), 2'b11, 16'h0);
    end
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R6", exp_q.size(), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule